// File: doc/BRIEF.md
# Shadowed SRAM with store/recall transfer engine

This block is a byte-wide static RAM in which every word has a nonvolatile shadow copy. The two arrays are linked by a transfer engine. In normal operation the host reads and writes the RAM through a simple synchronous port. A bulk transfer moves one word per clock between the two arrays, and the host port stays locked until the transfer ends.

There are two transfers. A store copies the RAM into the shadow. A recall first clears the RAM and then copies the shadow back into it. A rising edge on the power-fail input starts a store, and a rising edge on the power-good input starts a recall. Software can start either transfer by reading six fixed addresses in a row with no other access in between.

The address width is a parameter. With 15 address bits the array holds 32768 bytes. The default of 8 bits keeps the arrays small. The trigger addresses are compared on their low `ADDR_W` bits.

Top module: `nvsram_top`

## Requirements
- R1: When no transfer is running, a write (`hostReq`=1, `hostWe`=1) stores `hostWdata` at `hostAddr`. A read (`hostReq`=1, `hostWe`=0) returns that word on `rdData` with `rdValid`=1 one cycle after it is accepted. After reset `busy`, `done` and `rdValid` are 0.
- R2: A rising edge on `powerFail` while idle starts a store. `busy` is high for exactly 2^ADDR_W cycles, and afterwards the shadow holds a copy of every RAM word.
- R3: A rising edge on `powerGood` while idle starts a recall. The recall clears every RAM word, then copies every shadow word into the RAM. `busy` is high for exactly 2×2^ADDR_W cycles.
- R4: Six consecutive accepted reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0 (low ADDR_W bits compared) start a store on the cycle after the sixth read. The six reads still return data.
- R5: The same first five reads followed by a read at 0x0C63 start a recall.
- R6: The sequence is aborted by any write, or by any read at an address that is not the next one in the sequence. After an abort the sequence must restart from its first address. A read at the first address always begins a new attempt.
- R7: While `busy` is high, writes are dropped and reads give `rdValid`=0 and `rdData`=0. These accesses do not advance the sequence detector, and every transfer leaves the detector at its start.
- R8: A recall leaves the shadow unchanged, so repeated recalls return the same data.
- R9: `done` is a one-cycle pulse on the cycle after the last word of each transfer.
- R10: A `powerFail` rising edge during a recall is queued. The store then begins directly after the recall, with no idle cycle, so `busy` stays high for three times 2^ADDR_W cycles in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Host access request |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Word address |
| hostWdata | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, 0 when no valid read |
| rdValid | output | 1 | Read data valid, one cycle after an accepted read |
| powerFail | input | 1 | Rising edge requests a store |
| powerGood | input | 1 | Rising edge requests a recall |
| busy | output | 1 | Transfer in progress, host port locked |
| done | output | 1 | One-cycle pulse when a transfer completes |

## Verification
Read data and `rdValid` are due one cycle after the accepting edge. `busy` rises one cycle after a power edge or after the sixth trigger read. It then stays high for 2^ADDR_W store cycles or 2×2^ADDR_W recall cycles, and `done` rises on the cycle it falls. The bench drives inputs on falling edges and samples on the next falling edge. It counts falling edges while `busy` is high and compares the count with the exact length. It also checks `done` on the first falling edge after `busy` drops and again one edge later. Data checks compare whole-array read sweeps against a bench model of both arrays, which the bench updates at each write, store and recall.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_STORE = 2'd1,
    XF_CLEAR = 2'd2,
    XF_COPY  = 2'd3
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic hostEn;
    logic storeEn;
    logic clearEn;
    logic copyEn;
  } xferStrobe_t;

  localparam int SEQ_STEPS = 6;

  // trigger sequence words: steps 0..4 shared, 5 = store tail, 6 = recall tail
  function automatic logic [14:0] seqWord(input logic [2:0] k);
    case (k)
      3'd0:    return 15'h0E38;
      3'd1:    return 15'h31C7;
      3'd2:    return 15'h03E0;
      3'd3:    return 15'h3C1F;
      3'd4:    return 15'h303F;
      3'd5:    return 15'h0FC0;
      default: return 15'h0C63;
    endcase
  endfunction

endpackage

// File: rtl/nvsram_seq.sv
module nvsram_seq
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              acc,
  input  logic              isRead,
  input  logic [ADDR_W-1:0] addr,
  output logic              swStore,
  output logic              swRecall
);

  localparam logic [14:0] MASK = 15'((32'h1 << ADDR_W) - 1);
  localparam logic [2:0]  TAIL = 3'(SEQ_STEPS - 1);

  logic [2:0]  step;
  logic [14:0] addrX;
  logic        matchNext, matchFirst, matchStore, matchRecall;

  always_comb begin
    addrX       = 15'(addr);
    matchNext   = isRead && (addrX == (seqWord(step) & MASK));
    matchFirst  = isRead && (addrX == (seqWord(3'd0) & MASK));
    matchStore  = isRead && (addrX == (seqWord(3'd5) & MASK));
    matchRecall = isRead && (addrX == (seqWord(3'd6) & MASK));
    swStore     = acc && (step == TAIL) && matchStore;
    swRecall    = acc && (step == TAIL) && matchRecall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step <= '0;
    end else if (clr) begin
      step <= '0;
    end else if (acc) begin
      if (step != TAIL && matchNext) step <= step + 3'd1;
      else if (matchFirst)           step <= 3'd1;
      else                           step <= '0;
    end
  end

  // R6
  write_aborts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !isRead && !clr) |=> (step == 3'd0));

  // R4
  hit_resets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swStore || swRecall) |=> (step == 3'd0));

  // R7
  busy_holds_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (step == 3'd0));

endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerFail,
  input  logic              powerGood,
  input  logic              swStore,
  input  logic              swRecall,
  output xferStrobe_t       st,
  output logic [ADDR_W-1:0] idx,
  output logic              busy,
  output logic              done
);

  localparam logic [ADDR_W-1:0] LAST = '1;

  xferState_t state;
  logic       pfQ, pgQ, pendStore;
  logic       pfRise, pgRise, lastWord;

  always_comb begin
    pfRise     = powerFail && !pfQ;
    pgRise     = powerGood && !pgQ;
    lastWord   = (idx == LAST);
    busy       = (state != XF_IDLE);
    st.hostEn  = (state == XF_IDLE);
    st.storeEn = (state == XF_STORE);
    st.clearEn = (state == XF_CLEAR);
    st.copyEn  = (state == XF_COPY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= XF_IDLE;
      idx       <= '0;
      done      <= 1'b0;
      pendStore <= 1'b0;
      pfQ       <= 1'b0;
      pgQ       <= 1'b0;
    end else begin
      pfQ  <= powerFail;
      pgQ  <= powerGood;
      done <= 1'b0;
      case (state)
        XF_IDLE: begin
          idx <= '0;
          if (pfRise || (!pgRise && swStore)) state <= XF_STORE;
          else if (pgRise || swRecall)        state <= XF_CLEAR;
        end
        XF_STORE: begin
          idx <= idx + 1'b1;
          if (lastWord) begin
            state <= XF_IDLE;
            done  <= 1'b1;
          end
        end
        XF_CLEAR: begin
          idx <= idx + 1'b1;
          if (pfRise)   pendStore <= 1'b1;
          if (lastWord) state <= XF_COPY;
        end
        XF_COPY: begin
          idx <= idx + 1'b1;
          if (pfRise) pendStore <= 1'b1;
          if (lastWord) begin
            done      <= 1'b1;
            pendStore <= 1'b0;
            state     <= (pendStore || pfRise) ? XF_STORE : XF_IDLE;
          end
        end
        default: state <= XF_IDLE;
      endcase
    end
  end

  // R2
  pf_starts_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == XF_IDLE && pfRise) |=> (state == XF_STORE && idx == '0));

  // R3
  clear_then_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == XF_CLEAR && lastWord) |=> (state == XF_COPY && idx == '0));

  // R10
  queued_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == XF_COPY && lastWord && pendStore) |=> (state == XF_STORE));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

endmodule

// File: rtl/nvsram_dp.sv
module nvsram_dp
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       st,
  input  logic [ADDR_W-1:0] idx,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] sram   [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];
  logic              hostWr, hostRd;

  always_comb begin
    hostWr = st.hostEn && hostReq && hostWe;
    hostRd = st.hostEn && hostReq && !hostWe;
  end

  always_ff @(posedge clk) begin
    if (hostWr)          sram[hostAddr] <= hostWdata;
    else if (st.clearEn) sram[idx]      <= '0;
    else if (st.copyEn)  sram[idx]      <= shadow[idx];
  end

  always_ff @(posedge clk) begin
    if (st.storeEn) shadow[idx] <= sram[idx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= hostRd;
      rdData  <= hostRd ? sram[hostAddr] : '0;
    end
  end

  // R7
  locked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.hostEn) |=> (!rdValid && rdData == '0));

  // R3
  one_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.storeEn, st.clearEn, st.copyEn, st.hostEn}));

endmodule

// File: rtl/nvsram_top.sv
module nvsram_top
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic              powerFail,
  input  logic              powerGood,
  output logic              busy,
  output logic              done
);

  xferStrobe_t       st;
  logic [ADDR_W-1:0] idx;
  logic              swStore, swRecall;

  nvsram_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .clr      (busy),
    .acc      (hostReq && st.hostEn),
    .isRead   (!hostWe),
    .addr     (hostAddr),
    .swStore  (swStore),
    .swRecall (swRecall)
  );

  nvsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .powerFail (powerFail),
    .powerGood (powerGood),
    .swStore   (swStore),
    .swRecall  (swRecall),
    .st        (st),
    .idx       (idx),
    .busy      (busy),
    .done      (done)
  );

  nvsram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .idx       (idx),
    .hostReq   (hostReq),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

endmodule

// File: tb/test_nvsram_top.sv
module test_nvsram_top;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int D  = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostReq = 1'b0, hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0;
  logic [DW-1:0] rdData;
  logic          rdValid, busy, done;
  logic          powerFail = 1'b0, powerGood = 1'b0;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] expSram   [D];
  logic [DW-1:0] expShadow [D];
  logic [14:0]   seqFull   [7] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F,
                                   15'h303F, 15'h0FC0, 15'h0C63};

  always #2 clk = ~clk;

  nvsram_top i_nvsram_top (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .rdData(rdData),
    .rdValid(rdValid), .powerFail(powerFail), .powerGood(powerGood),
    .busy(busy), .done(done)
  );

  function automatic logic [DW-1:0] pat(input int a, input int seed);
    return DW'((a * 7 + seed * 13 + 1) & 8'hFF);
  endfunction

  function automatic logic [AW-1:0] seqA(input int k);
    logic [14:0] w;
    w = seqFull[k];
    return w[AW-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output bit v, output logic [DW-1:0] q);
    hostReq = 1'b1; hostWe = w; hostAddr = a; hostWdata = d;
    @(negedge clk);
    v = rdValid; q = rdData;
    hostReq = 1'b0; hostWe = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit v; logic [DW-1:0] q;
    access(1'b1, a, d, v, q);
    expSram[a] = d;
  endtask

  task automatic rdChk(input logic [AW-1:0] a, input string tag);
    bit v; logic [DW-1:0] q;
    access(1'b0, a, '0, v, q);
    chk(v == 1'b1, {tag, " rdValid"}, int'(v), 1);
    chk(q == expSram[a], {tag, " rdData"}, int'(q), int'(expSram[a]));
  endtask

  task automatic fillAll(input int seed);
    for (int a = 0; a < D; a++) wr(AW'(a), pat(a, seed));
  endtask

  task automatic sweepChk(input string tag);
    for (int a = 0; a < D; a++) rdChk(AW'(a), tag);
  endtask

  task automatic modelStore();
    for (int a = 0; a < D; a++) expShadow[a] = expSram[a];
  endtask

  task automatic modelRecall();
    for (int a = 0; a < D; a++) expSram[a] = expShadow[a];
  endtask

  // counts busy falling-edge samples starting at the current one
  task automatic xferWait(input int expN, input string tag);
    int n;
    n = 0;
    while (busy && n < 4 * D) begin n++; @(negedge clk); end
    chk(n == expN, {tag, " busy length"}, n, expN);
    chk(done == 1'b1, "R9 done pulse", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done width", int'(done), 0);
  endtask

  task automatic pulsePF();
    powerFail = 1'b1; @(negedge clk); powerFail = 1'b0;
  endtask

  task automatic pulsePG();
    powerGood = 1'b1; @(negedge clk); powerGood = 1'b0;
  endtask

  task automatic runSeq(input bit recall, input string tag);
    for (int k = 0; k < 6; k++) rdChk(seqA((k == 5 && recall) ? 6 : k), tag);
  endtask

  task automatic idleChk(input string tag);
    repeat (4) begin
      chk(busy == 1'b0, tag, int'(busy), 0);
      @(negedge clk);
    end
  endtask

  task automatic finishUp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishUp();
  end

  initial begin
    bit v; logic [DW-1:0] q;
    int n, dn;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(rdValid == 1'b0, "R1 reset rdValid", int'(rdValid), 0);

    // R1 plain RAM
    fillAll(1);
    sweepChk("R1");

    // R2 power-fail store
    pulsePF();
    xferWait(D, "R2");
    modelStore();

    // R3 power-good recall restores stored data
    fillAll(2);
    pulsePG();
    xferWait(2 * D, "R3");
    modelRecall();
    sweepChk("R3");

    // R8 repeated recall gives the same data
    fillAll(3);
    pulsePG();
    xferWait(2 * D, "R8");
    modelRecall();
    sweepChk("R8");

    // R4 software store
    fillAll(4);
    runSeq(1'b0, "R4");
    chk(busy == 1'b1, "R4 start", int'(busy), 1);
    xferWait(D, "R4");
    modelStore();
    fillAll(5);
    pulsePG();
    xferWait(2 * D, "R4");
    modelRecall();
    sweepChk("R4");

    // R5 software recall
    fillAll(6);
    runSeq(1'b1, "R5");
    chk(busy == 1'b1, "R5 start", int'(busy), 1);
    xferWait(2 * D, "R5");
    modelRecall();
    sweepChk("R5");

    // R6 interrupted by a write
    fillAll(7);
    for (int k = 0; k < 5; k++) rdChk(seqA(k), "R6");
    wr(AW'(3), 8'h5A);
    rdChk(seqA(5), "R6");
    idleChk("R6 write abort");
    // R6 interrupted by a foreign read
    for (int k = 0; k < 3; k++) rdChk(seqA(k), "R6");
    rdChk(AW'(8'h55), "R6");
    for (int k = 3; k < 6; k++) rdChk(seqA(k), "R6");
    idleChk("R6 read abort");
    // R6 repeated first address restarts the attempt
    rdChk(seqA(0), "R6");
    runSeq(1'b0, "R6");
    chk(busy == 1'b1, "R6 restart trigger", int'(busy), 1);
    xferWait(D, "R6");
    modelStore();
    fillAll(8);
    pulsePG();
    xferWait(2 * D, "R6");
    modelRecall();
    sweepChk("R6");

    // R7 host port locked during a store
    fillAll(9);
    pulsePF();
    modelStore();
    for (int k = 0; k < 4; k++) begin
      access(1'b1, AW'(k * 17), 8'hC3, v, q);
      access(1'b0, AW'(k * 17), '0, v, q);
      chk(v == 1'b0, "R7 locked rdValid", int'(v), 0);
      chk(q == '0, "R7 locked rdData", int'(q), 0);
    end
    for (int k = 0; k < 5; k++) access(1'b0, seqA(k), '0, v, q);
    while (busy) @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) rdChk(AW'(k * 17), "R7 dropped write");
    rdChk(seqA(5), "R7");
    idleChk("R7 detector untouched");

    // R10 power-fail queued during recall
    fillAll(10);
    pulsePG();
    n = 0; dn = 0;
    while (busy && n < 4 * D) begin
      if (done) dn++;
      if (n == 5) powerFail = 1'b1;
      if (n == 6) powerFail = 1'b0;
      n++;
      @(negedge clk);
    end
    if (done) dn++;
    chk(n == 3 * D, "R10 busy length", n, 3 * D);
    chk(dn == 2, "R10 done count", dn, 2);
    modelRecall();
    modelStore();
    @(negedge clk);
    sweepChk("R10");
    fillAll(11);
    pulsePG();
    xferWait(2 * D, "R10");
    modelRecall();
    sweepChk("R10");

    finishUp();
  end

endmodule